// File: doc/BRIEF.md
# Two-Lane Operand Forwarding Network

This block picks the operand values for a dual-issue, in-order pipeline. It handles four source operands: an A and a B operand for each of two lanes. Each source register index is compared with the destination index of every producer that sits in the execute/memory and memory/writeback pipeline registers of both lanes. The operand takes the newest eligible result. When no producer qualifies, it takes the register-file read value. Matching uses the architectural register number directly; there are no rename tags.

Age decides which producer wins. Any stage closer to execute beats a later stage, and at equal depth the higher lane beats the lower lane because it holds the younger instruction. A producer is eligible only when its valid flag and its register-write flag are both set, so squashed no-ops never forward. A load still in execute/memory carries only its address, so it is never forwarded from there. Its data reaches the consumer from memory/writeback instead, which is where a consumer picks it up after its one-cycle load-use stall. Register index 0 always reads as zero. The block is purely combinational and is meant to sit in front of the decode/execute register.

Top module: `fwd_network`

## Requirements
- R1: An operand whose source index is 0 reads as zero, whatever the producers hold.
- R2: When no producer in either stage has a valid write to the source register, the operand equals its register-file value.
- R3: An eligible execute/memory match wins over any memory/writeback match.
- R4: An eligible memory/writeback match wins over the register-file value.
- R5: Within one stage, a match in lane 1 wins over a match in lane 0.
- R6: A producer whose valid flag or write flag is clear is ignored, even when its destination equals the source.
- R7: An execute/memory producer with its load flag set is never forwarded. Selection falls through to memory/writeback or the register file.
- R8: A load result held in memory/writeback is forwarded to a consumer that reads its destination. This is the path a consumer uses after its load-use stall.
- R9: The four operands select independently. Operand k (index k = 2*lane + side, side 0 = A, 1 = B) uses only its own source index and its own register-file value.
- R10: A match needs all index bits equal. A destination that differs only in the top bit does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_idx | input | 4x3 | Source register index per operand (k = 2*lane + side) |
| rf_val | input | 4x16 | Register-file read value per operand |
| xm_dst | input | 2x3 | Execute/memory destination index per lane |
| xm_vld | input | 2 | Execute/memory valid per lane |
| xm_wen | input | 2 | Execute/memory register-write enable per lane |
| xm_ld | input | 2 | Execute/memory holds a load, per lane |
| xm_val | input | 2x16 | Execute/memory result per lane |
| mw_dst | input | 2x3 | Memory/writeback destination index per lane |
| mw_vld | input | 2 | Memory/writeback valid per lane |
| mw_wen | input | 2 | Memory/writeback register-write enable per lane |
| mw_val | input | 2x16 | Memory/writeback result (ALU or load data) per lane |
| opnd | output | 4x16 | Forwarded operand per operand |

## Verification
The main sweep runs every source index through every combination of four producer modes: eligible match, valid cleared, write cleared, and top-bit-only mismatch. It repeats this under each setting of the two execute/memory load flags, so it separates stage priority, lane priority, eligibility, load exclusion and full-index matching. Producer results and register-file values are all distinct, so every wrong selection shows up as a wrong value. Directed cases add an all-idle pipeline, a load moving from execute/memory into memory/writeback across two steps, and four operands with different indices applied at the same time.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef struct packed {
        logic vld;
        logic wen;
        logic ld;
    } prod_flags_t;

    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_ZERO = 2'd1,
        SRC_XM   = 2'd2,
        SRC_MW   = 2'd3
    } src_kind_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int IW        = 3,
    parameter bit TAKE_LOAD = 1'b1
) (
    input  logic [IW-1:0] src,
    input  logic [IW-1:0] dst,
    input  prod_flags_t   fl,
    output logic          hit
);
    logic load_ok;

    assign load_ok = TAKE_LOAD ? 1'b1 : !fl.ld;
    assign hit     = fl.vld && fl.wen && load_ok && (src == dst);
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int IW    = 3,
    parameter int DW    = 16
) (
    input  logic [IW-1:0]             src,
    input  logic [DW-1:0]             rf,
    input  logic [NLANE-1:0][IW-1:0]  xm_dst,
    input  prod_flags_t [NLANE-1:0]   xm_fl,
    input  logic [NLANE-1:0][DW-1:0]  xm_val,
    input  logic [NLANE-1:0][IW-1:0]  mw_dst,
    input  prod_flags_t [NLANE-1:0]   mw_fl,
    input  logic [NLANE-1:0][DW-1:0]  mw_val,
    output logic [DW-1:0]             val
);
    localparam int LW = (NLANE > 1) ? $clog2(NLANE) : 1;

    logic [NLANE-1:0] xm_hit;
    logic [NLANE-1:0] mw_hit;
    src_kind_t        kind;
    logic [LW-1:0]    sel;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        fwd_match #(.IW(IW), .TAKE_LOAD(1'b0)) u_xm (
            .src(src), .dst(xm_dst[l]), .fl(xm_fl[l]), .hit(xm_hit[l])
        );
        fwd_match #(.IW(IW), .TAKE_LOAD(1'b1)) u_mw (
            .src(src), .dst(mw_dst[l]), .fl(mw_fl[l]), .hit(mw_hit[l])
        );
    end

    // Lowest priority first; later assignments override earlier ones.
    always_comb begin
        kind = SRC_RF;
        sel  = '0;
        for (int l = 0; l < NLANE; l++) begin
            if (mw_hit[l]) begin
                kind = SRC_MW;
                sel  = LW'(l);
            end
        end
        for (int l = 0; l < NLANE; l++) begin
            if (xm_hit[l]) begin
                kind = SRC_XM;
                sel  = LW'(l);
            end
        end
        if (src == '0) kind = SRC_ZERO;
    end

    always_comb begin
        unique case (kind)
            SRC_ZERO: val = '0;
            SRC_XM:   val = xm_val[sel];
            SRC_MW:   val = mw_val[sel];
            default:  val = rf;
        endcase
    end
endmodule

// File: rtl/fwd_network.sv
module fwd_network
    import fwd_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int NREG  = 8,
    parameter int DW    = 16
) (
    input  logic [2*NLANE-1:0][$clog2(NREG)-1:0] src_idx,
    input  logic [2*NLANE-1:0][DW-1:0]           rf_val,
    input  logic [NLANE-1:0][$clog2(NREG)-1:0]   xm_dst,
    input  logic [NLANE-1:0]                     xm_vld,
    input  logic [NLANE-1:0]                     xm_wen,
    input  logic [NLANE-1:0]                     xm_ld,
    input  logic [NLANE-1:0][DW-1:0]             xm_val,
    input  logic [NLANE-1:0][$clog2(NREG)-1:0]   mw_dst,
    input  logic [NLANE-1:0]                     mw_vld,
    input  logic [NLANE-1:0]                     mw_wen,
    input  logic [NLANE-1:0][DW-1:0]             mw_val,
    output logic [2*NLANE-1:0][DW-1:0]           opnd
);
    localparam int IW   = $clog2(NREG);
    localparam int NOPS = 2 * NLANE;

    prod_flags_t [NLANE-1:0] xm_fl;
    prod_flags_t [NLANE-1:0] mw_fl;

    for (genvar l = 0; l < NLANE; l++) begin : g_flags
        assign xm_fl[l] = '{vld: xm_vld[l], wen: xm_wen[l], ld: xm_ld[l]};
        assign mw_fl[l] = '{vld: mw_vld[l], wen: mw_wen[l], ld: 1'b0};
    end

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        fwd_operand_mux #(.NLANE(NLANE), .IW(IW), .DW(DW)) u_mux (
            .src    (src_idx[k]),
            .rf     (rf_val[k]),
            .xm_dst (xm_dst),
            .xm_fl  (xm_fl),
            .xm_val (xm_val),
            .mw_dst (mw_dst),
            .mw_fl  (mw_fl),
            .mw_val (mw_val),
            .val    (opnd[k])
        );
    end
endmodule

// File: rtl/fwd_network_chk.sv
module fwd_network_chk #(
    parameter int NLANE = 2,
    parameter int NREG  = 8,
    parameter int DW    = 16
) (
    input logic [2*NLANE-1:0][$clog2(NREG)-1:0] src_idx,
    input logic [2*NLANE-1:0][DW-1:0]           rf_val,
    input logic [NLANE-1:0][$clog2(NREG)-1:0]   xm_dst,
    input logic [NLANE-1:0]                     xm_vld,
    input logic [NLANE-1:0]                     xm_wen,
    input logic [NLANE-1:0]                     xm_ld,
    input logic [NLANE-1:0][DW-1:0]             xm_val,
    input logic [NLANE-1:0][$clog2(NREG)-1:0]   mw_dst,
    input logic [NLANE-1:0]                     mw_vld,
    input logic [NLANE-1:0]                     mw_wen,
    input logic [NLANE-1:0][DW-1:0]             mw_val,
    input logic [2*NLANE-1:0][DW-1:0]           opnd
);
    localparam int TOP = NLANE - 1;

    always_comb begin
        for (int k = 0; k < 2 * NLANE; k++) begin
            logic any_xm_touch;
            logic any_mw_touch;
            any_xm_touch = 1'b0;
            any_mw_touch = 1'b0;
            for (int l = 0; l < NLANE; l++) begin
                if (xm_vld[l] && xm_dst[l] == src_idx[k]) any_xm_touch = 1'b1;
                if (mw_vld[l] && mw_dst[l] == src_idx[k]) any_mw_touch = 1'b1;
            end

            assert_zero_index_R1: assert (src_idx[k] != '0 || opnd[k] == '0)
                else $error("operand %0d nonzero for index 0", k);

            // R3 and R5: the youngest lane in execute/memory wins outright
            assert_xm_top_lane_R3: assert (!(src_idx[k] != '0 && xm_vld[TOP] && xm_wen[TOP]
                                             && !xm_ld[TOP] && xm_dst[TOP] == src_idx[k])
                                           || opnd[k] == xm_val[TOP])
                else $error("operand %0d missed execute/memory lane %0d", k, TOP);

            assert_mw_over_rf_R4: assert (!(src_idx[k] != '0 && !any_xm_touch && mw_vld[TOP]
                                            && mw_wen[TOP] && mw_dst[TOP] == src_idx[k])
                                          || opnd[k] == mw_val[TOP])
                else $error("operand %0d missed memory/writeback lane %0d", k, TOP);

            assert_rf_fallback_R2: assert (!(src_idx[k] != '0 && !any_xm_touch && !any_mw_touch)
                                           || opnd[k] == rf_val[k])
                else $error("operand %0d did not fall back to register file", k);
        end
    end
endmodule

bind fwd_network fwd_network_chk #(.NLANE(NLANE), .NREG(NREG), .DW(DW)) u_chk (
    .src_idx(src_idx), .rf_val(rf_val),
    .xm_dst(xm_dst), .xm_vld(xm_vld), .xm_wen(xm_wen), .xm_ld(xm_ld), .xm_val(xm_val),
    .mw_dst(mw_dst), .mw_vld(mw_vld), .mw_wen(mw_wen), .mw_val(mw_val),
    .opnd(opnd)
);

// File: tb/tb_fwd_network.sv
module tb_fwd_network;
    localparam int NLANE = 2;
    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int IW    = 3;
    localparam int NOPS  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NOPS-1:0][IW-1:0]  src_idx;
    logic [NOPS-1:0][DW-1:0]  rf_val;
    logic [NLANE-1:0][IW-1:0] xm_dst, mw_dst;
    logic [NLANE-1:0]         xm_vld, xm_wen, xm_ld, mw_vld, mw_wen;
    logic [NLANE-1:0][DW-1:0] xm_val, mw_val;
    logic [NOPS-1:0][DW-1:0]  opnd;

    fwd_network #(.NLANE(NLANE), .NREG(NREG), .DW(DW)) dut (
        .src_idx(src_idx), .rf_val(rf_val),
        .xm_dst(xm_dst), .xm_vld(xm_vld), .xm_wen(xm_wen), .xm_ld(xm_ld), .xm_val(xm_val),
        .mw_dst(mw_dst), .mw_vld(mw_vld), .mw_wen(mw_wen), .mw_val(mw_val),
        .opnd(opnd)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input int k, input logic [DW-1:0] exp, input string req);
        n_tests++;
        if (opnd[k] !== exp) begin
            n_fail++;
            $display("FAIL %s operand %0d: actual %h expected %h", req, k, opnd[k], exp);
        end
    endtask

    task automatic idle_all();
        src_idx = '0; xm_dst = '0; mw_dst = '0;
        xm_vld = '0; xm_wen = '0; xm_ld = '0; mw_vld = '0; mw_wen = '0;
        for (int l = 0; l < NLANE; l++) begin
            xm_val[l] = DW'(16'hA000 + l);
            mw_val[l] = DW'(16'hB000 + l);
        end
        for (int k = 0; k < NOPS; k++) rf_val[k] = DW'(16'hC000 + k);
    endtask

    // mode: 0 eligible match, 1 valid clear, 2 write clear, 3 top-bit mismatch
    function automatic logic [IW-1:0] dst_of(input int mode, input logic [IW-1:0] s);
        return (mode == 3) ? (s ^ 3'b100) : s;
    endfunction

    initial begin
        idle_all();
        @(posedge clk); @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NOPS; k++) check(k, '0, "R1 reset-idle");

        // R2: indices nonzero, pipeline idle
        for (int k = 0; k < NOPS; k++) src_idx[k] = IW'(k + 1);
        @(negedge clk);
        for (int k = 0; k < NOPS; k++) check(k, DW'(16'hC000 + k), "R2");

        // R9: distinct indices, each hitting a different producer
        src_idx[0] = 3'd2; src_idx[1] = 3'd5; src_idx[2] = 3'd0; src_idx[3] = 3'd7;
        xm_dst[0] = 3'd2; xm_vld[0] = 1'b1; xm_wen[0] = 1'b1;
        mw_dst[1] = 3'd5; mw_vld[1] = 1'b1; mw_wen[1] = 1'b1;
        @(negedge clk);
        check(0, 16'hA000, "R9");
        check(1, 16'hB001, "R9");
        check(2, 16'h0000, "R9");
        check(3, 16'hC003, "R9");

        // R7 then R8: load travels from execute/memory to memory/writeback
        idle_all();
        for (int k = 0; k < NOPS; k++) src_idx[k] = 3'd3;
        rf_val[0] = 16'h1111;
        xm_dst[0] = 3'd3; xm_vld[0] = 1'b1; xm_wen[0] = 1'b1; xm_ld[0] = 1'b1;
        xm_val[0] = 16'h0040;
        @(negedge clk);
        check(0, 16'h1111, "R7 load in execute/memory");
        xm_vld[0] = 1'b0; xm_ld[0] = 1'b0;
        mw_dst[0] = 3'd3; mw_vld[0] = 1'b1; mw_wen[0] = 1'b1; mw_val[0] = 16'hBEEF;
        @(negedge clk);
        check(0, 16'hBEEF, "R8 load data from memory/writeback");

        // Sweep: index x producer modes x load flags
        for (int s = 0; s < NREG; s++) begin
            for (int p = 0; p < 256; p++) begin
                for (int ld = 0; ld < 4; ld++) begin
                    int mode [4];
                    logic [DW-1:0] exp [NOPS];
                    string req;
                    int winner;
                    bit inelig, mism, ld_skip;
                    idle_all();
                    for (int i = 0; i < 4; i++) mode[i] = (p >> (2 * i)) & 3;
                    for (int k = 0; k < NOPS; k++) src_idx[k] = IW'(s);
                    // producers 0,1 = xm lane 0,1 ; 2,3 = mw lane 0,1
                    for (int l = 0; l < NLANE; l++) begin
                        xm_dst[l] = dst_of(mode[l], IW'(s));
                        xm_vld[l] = (mode[l] != 1);
                        xm_wen[l] = (mode[l] != 2);
                        xm_ld[l]  = ((ld >> l) & 1) != 0;
                        mw_dst[l] = dst_of(mode[l + 2], IW'(s));
                        mw_vld[l] = (mode[l + 2] != 1);
                        mw_wen[l] = (mode[l + 2] != 2);
                    end
                    // expected: xm lane1, xm lane0, mw lane1, mw lane0, rf
                    winner = -1; ld_skip = 0;
                    for (int l = NLANE - 1; l >= 0; l--)
                        if (winner < 0 && mode[l] == 0) begin
                            if (((ld >> l) & 1) != 0) ld_skip = 1;
                            else winner = l;
                        end
                    for (int l = NLANE - 1; l >= 0; l--)
                        if (winner < 0 && mode[l + 2] == 0) winner = l + 2;
                    inelig = 0; mism = 0;
                    for (int i = 0; i < 4; i++) begin
                        if (mode[i] == 1 || mode[i] == 2) inelig = 1;
                        if (mode[i] == 3) mism = 1;
                    end
                    if (s == 0) req = "R1";
                    else if (ld_skip) req = "R7";
                    else if (winner == 1 && mode[0] == 0) req = "R5 xm lanes";
                    else if (winner == 3 && mode[2] == 0) req = "R5 mw lanes";
                    else if (winner >= 0 && winner < 2) req = "R3";
                    else if (winner >= 2) req = "R4";
                    else if (inelig) req = "R6";
                    else if (mism) req = "R10";
                    else req = "R2";
                    for (int k = 0; k < NOPS; k++) begin
                        if (s == 0)          exp[k] = '0;
                        else if (winner < 0) exp[k] = DW'(16'hC000 + k);
                        else if (winner < 2) exp[k] = DW'(16'hA000 + winner);
                        else                 exp[k] = DW'(16'hB000 + winner - 2);
                    end
                    #5;
                    for (int k = 0; k < NOPS; k++) check(k, exp[k], req);
                    #5;
                end
            end
        end
        done = 1'b1;
    end

    int wd = 0;
    initial begin
        while (!done && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule